// File: doc/BRIEF.md
# Linear Page Table Walker

This block services translation misses in hardware. When the translation buffer misses, it hands the walker a virtual page number. The walker builds the address of that page's entry in a single-level linear table in memory. The address is the table base plus the page number scaled by the entry size in bytes. The walker issues one read on a request/response memory port and waits for the reply, which may take any number of cycles. It then decodes the returned entry.

If the entry says the page is resident, the walker returns a refill to the translation buffer. The refill carries the physical page number and the permission bits. If the page lives on disk, the page number field holds a disk page number instead. In that case the walker raises a page fault and writes nothing back into the buffer.

Software reloads the table base whenever the running process changes. A reload that arrives while a walk is under way is held back until the walker is idle again, so a walk never mixes two tables.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: miss_ready is 1, mem_req_valid, done, refill_valid and page_fault are 0, and the table base is 0.
- R2: The entry read address equals base + 4 × VPN, taken modulo 2^ADDR_W.
- R3: While mem_req_valid is high and mem_req_ready is low, the request stays asserted and mem_req_addr does not change.
- R4: A miss is accepted only when miss_ready is high, which is only in the idle state. miss_valid raised during a walk has no effect on that walk's address or its reported VPN.
- R5: The response may arrive any number of cycles after the request is accepted. mem_resp_valid is ignored unless the walker is waiting for its own read.
- R6: An entry with bit 31 set (present) ends the walk with refill_valid = 1 and page_fault = 0. done_pn carries bits 19:0 (the physical page number) and done_perm carries bits 30:28 as {read, write, user}.
- R7: An entry with bit 31 clear ends the walk with page_fault = 1 and refill_valid = 0. done_pn carries bits 19:0 (the disk page number).
- R8: Each walk produces exactly one done pulse, one cycle long, two cycles after the response is sampled at most. refill_valid and page_fault are high only together with done, and exactly one of them is high.
- R9: A base write while idle takes effect for the next walk. A base write during a walk leaves that walk's address unchanged. It is applied when the walker returns to idle, and the last such write wins.
- R10: Each walk performs exactly one memory read handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Translation miss request |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| miss_ready | output | 1 | Walker idle and able to accept a miss |
| base_wr_en | input | 1 | Write strobe for the table base |
| base_wr_data | input | ADDR_W | New table base address |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_addr | output | ADDR_W | Byte address of the entry |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_resp_valid | input | 1 | Read data valid |
| mem_resp_data | input | 32 | Fetched table entry |
| done | output | 1 | One-cycle pulse at the end of a walk |
| refill_valid | output | 1 | Walk produced a refill |
| page_fault | output | 1 | Walk found a non-resident page |
| done_vpn | output | VPN_W | Virtual page number of the finished walk |
| done_pn | output | PN_W | Physical or disk page number from the entry |
| done_perm | output | 3 | Permission bits {read, write, user} |

## Verification
Random walks mix resident and non-resident entries, random page numbers and random request and response latencies. These walks separate the refill path from the fault path and show that neither depends on timing. Directed walks use page number zero, the all-ones page number with a base near the top of the address space, and each permission pattern; these expose errors in address scaling, carry and field extraction. Other walks overlay disturbances on a walk in progress: stray responses before the request is accepted, a second miss during a walk, and one or two base writes mid-walk. A result that differs from the undisturbed expectation then points at state that should have been frozen.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    // Entry layout; the decoder and the bench both rely on these positions.
    localparam int PTE_W       = 32;
    localparam int PRESENT_BIT = 31;
    localparam int PERM_HI     = 30;
    localparam int PERM_LO     = 28;
    localparam int PERM_W      = PERM_HI - PERM_LO + 1;
    localparam int ENTRY_BYTES = PTE_W / 8;
    localparam int ENTRY_SHIFT = $clog2(ENTRY_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_READ_REQ  = 2'd1,
        ST_WAIT_RESP = 2'd2,
        ST_DONE      = 2'd3
    } walk_state_t;

    typedef struct packed {
        logic readable;
        logic writable;
        logic user_ok;
    } perm_t;

    function automatic logic entry_present(input logic [PTE_W-1:0] e);
        return e[PRESENT_BIT];
    endfunction

    function automatic perm_t entry_perm(input logic [PTE_W-1:0] e);
        return perm_t'(e[PERM_HI:PERM_LO]);
    endfunction

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg
    import pt_walker_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              idle,
    output logic [ADDR_W-1:0] base_q
);

    logic              pend_q;
    logic [ADDR_W-1:0] pend_data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q      <= '0;
            pend_q      <= 1'b0;
            pend_data_q <= '0;
        end else if (wr_en && idle) begin
            base_q <= wr_data;
            pend_q <= 1'b0;
        end else if (wr_en) begin
            pend_q      <= 1'b1;
            pend_data_q <= wr_data;
        end else if (pend_q && idle) begin
            base_q <= pend_data_q;
            pend_q <= 1'b0;
        end
    end

endmodule

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import pt_walker_pkg::*;
#(
    parameter int PN_W = 20
) (
    input  logic [PTE_W-1:0] entry,
    output logic             present,
    output perm_t            perm,
    output logic [PN_W-1:0]  pn
);

    localparam int RSVD_W = PERM_LO - PN_W;

    assign present = entry_present(entry);
    assign perm    = entry_perm(entry);
    assign pn      = entry[PN_W-1:0];

    generate
        if (RSVD_W > 0) begin : g_rsvd
            logic unused_rsvd;
            assign unused_rsvd = ^entry[PERM_LO-1:PN_W];
        end
    endgenerate

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import pt_walker_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ADDR_W = 32,
    parameter int PN_W   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    output logic              idle,
    input  logic [ADDR_W-1:0] base_q,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_resp_valid,
    input  logic              ent_present,
    input  perm_t             ent_perm,
    input  logic [PN_W-1:0]   ent_pn,
    output logic              done,
    output logic              refill_valid,
    output logic              page_fault,
    output logic [VPN_W-1:0]  done_vpn,
    output logic [PN_W-1:0]   done_pn,
    output perm_t             done_perm
);

    walk_state_t      state_q, state_d;
    logic [VPN_W-1:0] vpn_q;
    logic             take_resp;

    assign idle          = (state_q == ST_IDLE);
    assign mem_req_valid = (state_q == ST_READ_REQ);
    assign mem_req_addr  = base_q + (ADDR_W'(vpn_q) << ENTRY_SHIFT);
    assign take_resp     = (state_q == ST_WAIT_RESP) && mem_resp_valid;
    assign done_vpn      = vpn_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (miss_valid)    state_d = ST_READ_REQ;
            ST_READ_REQ:  if (mem_req_ready) state_d = ST_WAIT_RESP;
            ST_WAIT_RESP: if (mem_resp_valid) state_d = ST_DONE;
            ST_DONE:                          state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vpn_q   <= '0;
        end else begin
            state_q <= state_d;
            if (idle && miss_valid) vpn_q <= miss_vpn;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done         <= 1'b0;
            refill_valid <= 1'b0;
            page_fault   <= 1'b0;
            done_pn      <= '0;
            done_perm    <= '0;
        end else if (take_resp) begin
            done         <= 1'b1;
            refill_valid <= ent_present;
            page_fault   <= !ent_present;
            done_pn      <= ent_pn;
            done_perm    <= ent_perm;
        end else begin
            done         <= 1'b0;
            refill_valid <= 1'b0;
            page_fault   <= 1'b0;
        end
    end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int VPN_W  = 20,
    parameter int ADDR_W = 32,
    parameter int PN_W   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              miss_valid,
    input  logic [VPN_W-1:0]  miss_vpn,
    output logic              miss_ready,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] base_wr_data,
    output logic              mem_req_valid,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_req_ready,
    input  logic              mem_resp_valid,
    input  logic [31:0]       mem_resp_data,
    output logic              done,
    output logic              refill_valid,
    output logic              page_fault,
    output logic [VPN_W-1:0]  done_vpn,
    output logic [PN_W-1:0]   done_pn,
    output logic [2:0]        done_perm
);

    logic              idle;
    logic [ADDR_W-1:0] base_q;
    logic              ent_present;
    perm_t             ent_perm;
    logic [PN_W-1:0]   ent_pn;
    perm_t             perm_out;

    assign miss_ready = idle;
    assign done_perm  = perm_out;

    ptw_base_reg #(.ADDR_W(ADDR_W)) u_base (
        .clk(clk), .rst(rst), .wr_en(base_wr_en), .wr_data(base_wr_data),
        .idle(idle), .base_q(base_q)
    );

    ptw_entry_decode #(.PN_W(PN_W)) u_dec (
        .entry(mem_resp_data), .present(ent_present), .perm(ent_perm), .pn(ent_pn)
    );

    ptw_fsm #(.VPN_W(VPN_W), .ADDR_W(ADDR_W), .PN_W(PN_W)) u_fsm (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .idle(idle), .base_q(base_q),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
        .ent_present(ent_present), .ent_perm(ent_perm), .ent_pn(ent_pn),
        .done(done), .refill_valid(refill_valid), .page_fault(page_fault),
        .done_vpn(done_vpn), .done_pn(done_pn), .done_perm(perm_out)
    );

endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
    parameter int VPN_W  = 20,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic              miss_valid,
    input logic [VPN_W-1:0]  miss_vpn,
    input logic              miss_ready,
    input logic              mem_req_valid,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_req_ready,
    input logic              done,
    input logic              refill_valid,
    input logic              page_fault,
    input logic [VPN_W-1:0]  done_vpn
);

    logic [1:0]       req_cnt;
    logic [VPN_W-1:0] vpn_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_cnt  <= '0;
            vpn_seen <= '0;
        end else if (miss_valid && miss_ready) begin
            req_cnt  <= '0;
            vpn_seen <= miss_vpn;
        end else if (mem_req_valid && mem_req_ready && req_cnt != 2'd3) begin
            req_cnt <= req_cnt + 2'd1;
        end
    end

    // R1
    idle_no_req_chk: assert property (@(posedge clk) disable iff (rst)
        miss_ready |-> !mem_req_valid && !done);

    // R3
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R4
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        miss_valid && miss_ready |=> !miss_ready);

    // R4
    done_vpn_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> done_vpn == vpn_seen);

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    result_excl_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (refill_valid ^ page_fault));

    // R8
    result_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (refill_valid || page_fault) |-> done);

    // R10
    one_read_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> req_cnt == 2'd1);

endmodule

bind pt_walker ptw_checker #(.VPN_W(VPN_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
    .miss_ready(miss_ready), .mem_req_valid(mem_req_valid),
    .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .done(done), .refill_valid(refill_valid), .page_fault(page_fault),
    .done_vpn(done_vpn)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;

    localparam int VPN_W  = 20;
    localparam int ADDR_W = 32;
    localparam int PN_W   = 20;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              miss_valid = 1'b0;
    logic [VPN_W-1:0]  miss_vpn = '0;
    logic              miss_ready;
    logic              base_wr_en = 1'b0;
    logic [ADDR_W-1:0] base_wr_data = '0;
    logic              mem_req_valid;
    logic [ADDR_W-1:0] mem_req_addr;
    logic              mem_req_ready = 1'b0;
    logic              mem_resp_valid = 1'b0;
    logic [31:0]       mem_resp_data = '0;
    logic              done, refill_valid, page_fault;
    logic [VPN_W-1:0]  done_vpn;
    logic [PN_W-1:0]   done_pn;
    logic [2:0]        done_perm;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    bit finished = 1'b0;
    logic [ADDR_W-1:0] model_base = '0;

    always #5 clk = ~clk;

    pt_walker #(.VPN_W(VPN_W), .ADDR_W(ADDR_W), .PN_W(PN_W)) i_pt_walker (
        .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_vpn(miss_vpn),
        .miss_ready(miss_ready), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
        .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
        .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
        .mem_resp_data(mem_resp_data), .done(done), .refill_valid(refill_valid),
        .page_fault(page_fault), .done_vpn(done_vpn), .done_pn(done_pn),
        .done_perm(done_perm)
    );

    function automatic logic [ADDR_W-1:0] exp_addr(input logic [ADDR_W-1:0] b,
                                                   input logic [VPN_W-1:0] v);
        return b + {{(ADDR_W-VPN_W-2){1'b0}}, v, 2'b00};
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            n_fails++;
            $display("FAIL R8 watchdog: actual %0d cycles expected < %0d", cycles, 150000);
            summary();
        end
    end

    task automatic base_write_idle(input logic [ADDR_W-1:0] v);
        @(negedge clk);
        base_wr_en = 1'b1; base_wr_data = v;
        @(negedge clk);
        base_wr_en = 1'b0;
        model_base = v;
    endtask

    // One walk; flags add disturbances during the request hold phase.
    task automatic walk(input logic [VPN_W-1:0] vpn, input logic [31:0] pte,
                        input int req_delay, input int resp_delay,
                        input bit mid_write, input logic [ADDR_W-1:0] wv1,
                        input logic [ADDR_W-1:0] wv2,
                        input bit busy_miss, input bit stray);
        logic [ADDR_W-1:0] a;
        int rd;
        rd = (mid_write && req_delay < 2) ? 2 : req_delay;
        @(negedge clk);
        check(miss_ready == 1'b1, "R4 ready before miss", miss_ready, 1);
        miss_valid = 1'b1; miss_vpn = vpn;
        @(negedge clk);
        miss_valid = 1'b0;
        a = exp_addr(model_base, vpn);
        check(mem_req_valid && mem_req_addr == a, "R2 entry address", mem_req_addr, a);
        check(miss_ready == 1'b0, "R4 busy after accept", miss_ready, 0);
        for (int i = 0; i < rd; i++) begin
            if (busy_miss) begin miss_valid = 1'b1; miss_vpn = ~vpn; end
            if (stray && i == 0) begin mem_resp_valid = 1'b1; mem_resp_data = ~pte; end
            if (mid_write && i == 0) begin base_wr_en = 1'b1; base_wr_data = wv1; end
            if (mid_write && i == 1) begin base_wr_en = 1'b1; base_wr_data = wv2; end
            @(negedge clk);
            mem_resp_valid = 1'b0; base_wr_en = 1'b0;
            check(mem_req_valid && mem_req_addr == a, "R3 held request", mem_req_addr, a);
        end
        miss_valid = 1'b0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid == 1'b0, "R10 single read", mem_req_valid, 0);
        for (int i = 0; i < resp_delay; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R5 no done before response", done, 0);
        end
        mem_resp_valid = 1'b1; mem_resp_data = pte;
        @(negedge clk);
        mem_resp_valid = 1'b0;
        check(done == 1'b1, "R8 done pulse", done, 1);
        check(done_vpn == vpn, "R4 done vpn", done_vpn, vpn);
        check(done_pn == pte[19:0], pte[31] ? "R6 physical page" : "R7 disk page",
              done_pn, pte[19:0]);
        if (pte[31]) begin
            check(refill_valid && !page_fault, "R6 refill", {refill_valid, page_fault}, 2'b10);
            check(done_perm == pte[30:28], "R6 perm", done_perm, pte[30:28]);
        end else begin
            check(!refill_valid && page_fault, "R7 fault", {refill_valid, page_fault}, 2'b01);
        end
        @(negedge clk);
        check(!done && !refill_valid && !page_fault, "R8 single pulse",
              {done, refill_valid, page_fault}, 0);
        if (mid_write) model_base = wv2;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(miss_ready && !mem_req_valid && !done && !refill_valid && !page_fault,
              "R1 reset state", {miss_ready, mem_req_valid, done, refill_valid, page_fault},
              5'b10000);
        // R1: base is zero after reset
        walk(20'h00012, 32'h8000_0123, 0, 0, 0, '0, '0, 0, 0);
        // R5: stray response while idle
        @(negedge clk); mem_resp_valid = 1'b1; mem_resp_data = 32'h8000_0001;
        @(negedge clk); mem_resp_valid = 1'b0;
        check(!done && miss_ready, "R5 idle response ignored", done, 0);
        // R2: wraparound at top of address space, VPN zero
        base_write_idle(32'hFFFF_FFF0);
        walk(20'hFFFFF, 32'h0000_0ABC, 1, 2, 0, '0, '0, 0, 0);
        walk(20'h00000, 32'hF000_0000, 0, 1, 0, '0, '0, 0, 0);
        // R6: every permission pattern
        base_write_idle(32'h0010_0000);
        for (int p = 0; p < 8; p++)
            walk(VPN_W'(p * 3 + 1), {1'b1, 3'(p), 8'h00, 20'(p * 4099)}, p % 3, p % 4, 0, '0, '0, 0, 0);
        // R7: non-resident with all-ones disk page
        walk(20'h0ABCD, 32'h7FFF_FFFF, 2, 5, 0, '0, '0, 0, 0);
        // R9: two writes mid walk; next walk uses the last one
        walk(20'h00100, 32'h8123_4567, 3, 1, 1, 32'hAAAA_0000, 32'h5555_0000, 0, 0);
        walk(20'h00100, 32'h8000_0042, 0, 0, 0, '0, '0, 0, 0);
        // R4, R5: busy miss and early stray response
        walk(20'h00321, 32'h9000_0777, 2, 3, 0, '0, '0, 1, 1);
        // random walks
        for (int n = 0; n < 300; n++) begin
            logic [VPN_W-1:0] v;
            logic [31:0] e;
            bit mw;
            v  = VPN_W'($urandom);
            e  = $urandom;
            mw = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 9) == 0) base_write_idle($urandom);
            walk(v, e, $urandom_range(0, 4), $urandom_range(0, 6), mw,
                 $urandom, $urandom, $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0);
        end
        summary();
    end

endmodule